// File: doc/BRIEF.md
# Real-Mode Segmented Address Generator

This block forms a linear memory address from a 16-bit segment base and a 16-bit offset, as a legacy 16-bit processor does in real mode. It holds four segment base registers. Each access request picks one of them, shifts its value left by four bits and adds the offset. A write port loads the base registers. A single gate register decides whether the carry out of the 20-bit range reaches address bit 20 or is forced to zero.

With the gate open, the roughly 64 KiB just above 1 MiB can be reached. With the gate closed, addresses past 1 MiB fold back onto low memory. The result is registered one clock after the request and comes with a valid strobe. A wrap flag reports the raw carry into bit 20 whatever the gate setting, so aliasing can be seen at the ports.

Top module: `seg_addr_unit`

## Requirements
- R1: While reset is asserted and just after it is released, all four base registers hold zero, the gate is closed (masking), `lin_valid` is 0, and `lin_addr` and `lin_wrap` are 0.
- R2: A request with `req_valid` high produces, one clock later, `lin_valid` high and `lin_addr` equal to base*16 + offset, with bit 20 gated as in R5 and R6. `lin_valid` is low in the cycle after a clock with no request.
- R3: `req_sel` and `seg_wsel` use the same encoding: 0 = code, 1 = data, 2 = stack, 3 = extra.
- R4: When `seg_we` is high, the base register chosen by `seg_wsel` takes `seg_wdata` at the clock edge. The other three base registers keep their values.
- R5: When the gate is open (last `gate_wdata` written was 1), the carry reaches bit 20. Base FFFFh with offset FFFFh gives 10FFEFh.
- R6: When the gate is closed, bit 20 of `lin_addr` is 0 and bits 19:0 equal those of the raw sum. Base FFFFh with offset 0010h gives 000000h.
- R7: `lin_wrap` equals bit 20 of the raw sum, in both gate states.
- R8: Base FFFFh with offset 0000h gives FFFF0h with `lin_wrap` low.
- R9: In a cycle with no request, `lin_addr` and `lin_wrap` keep their previous values.
- R10: A base-register write or gate write made in the same clock as a request does not affect that request. The request uses the values held before that edge, and the new value applies from the next request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_we | input | 1 | Base register write enable |
| seg_wsel | input | 2 | Base register to write (R3 encoding) |
| seg_wdata | input | 16 | Value to write |
| gate_we | input | 1 | Gate register write enable |
| gate_wdata | input | 1 | Gate value: 1 open, 0 masking |
| req_valid | input | 1 | Address request strobe |
| req_sel | input | 2 | Base register used by the request |
| req_off | input | 16 | Request offset |
| lin_valid | output | 1 | Result valid, one clock after the request |
| lin_addr | output | 21 | Linear address |
| lin_wrap | output | 1 | Raw carry into bit 20 |

## Verification
The bench builds the block with its default parameters: a 16-bit segment, a 16-bit offset and a 4-bit shift. This puts the full 21-bit result range within reach, including the 10FFEFh top and the fold-back region. Each of several sets of base values is loaded and rotated across all four registers. Offsets are swept in steps across the whole 16-bit range plus the extremes, with both gate states. Every expected value is computed arithmetically from base and offset.

// File: rtl/seg_addr_unit.sv
module seg_addr_unit #(
  parameter int SEG_W   = 16,
  parameter int OFF_W   = 16,
  parameter int SHIFT   = 4,
  parameter int NUM_SEG = 4,
  parameter int SEL_W   = $clog2(NUM_SEG),
  parameter int ADDR_W  = SEG_W + SHIFT + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seg_we,
  input  logic [SEL_W-1:0]  seg_wsel,
  input  logic [SEG_W-1:0]  seg_wdata,
  input  logic              gate_we,
  input  logic              gate_wdata,
  input  logic              req_valid,
  input  logic [SEL_W-1:0]  req_sel,
  input  logic [OFF_W-1:0]  req_off,
  output logic              lin_valid,
  output logic [ADDR_W-1:0] lin_addr,
  output logic              lin_wrap
);
  localparam int TOP = ADDR_W - 1;

  logic [SEG_W-1:0] seg_q [NUM_SEG];
  logic             gate_q;

  for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg
    always_ff @(posedge clk) begin
      if (!rst_n)
        seg_q[i] <= '0;
      else if (seg_we && seg_wsel == SEL_W'(i))
        seg_q[i] <= seg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       gate_q <= 1'b0;
    else if (gate_we) gate_q <= gate_wdata;
  end

  wire [ADDR_W-1:0] raw   = {1'b0, seg_q[req_sel], {SHIFT{1'b0}}}
                          + {{(ADDR_W-OFF_W){1'b0}}, req_off};
  wire [ADDR_W-1:0] gated = {raw[TOP] & gate_q, raw[TOP-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lin_valid <= 1'b0;
      lin_addr  <= '0;
      lin_wrap  <= 1'b0;
    end else begin
      lin_valid <= req_valid;
      if (req_valid) begin
        lin_addr <= gated;
        lin_wrap <= raw[TOP];
      end
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> lin_valid);
  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !lin_valid);
  // R2
  low_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> lin_addr[SHIFT-1:0] == $past(req_off[SHIFT-1:0]));
  // R6
  masked_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !gate_q) |=> !lin_addr[TOP]);
  // R7
  top_needs_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lin_addr[TOP] |-> lin_wrap);
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(lin_addr) && $stable(lin_wrap)));
endmodule

// File: tb/tb_seg_addr_unit.sv
`timescale 1ns/1ps
module tb_seg_addr_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        seg_we, gate_we, gate_wdata, req_valid;
  logic [1:0]  seg_wsel, req_sel;
  logic [15:0] seg_wdata, req_off;
  logic        lin_valid, lin_wrap;
  logic [20:0] lin_addr;

  int checks = 0;
  int errors = 0;
  logic [15:0] model [4];
  logic        gate_m;

  always #2.5 clk = ~clk;

  seg_addr_unit dut (
    .clk(clk), .rst_n(rst_n),
    .seg_we(seg_we), .seg_wsel(seg_wsel), .seg_wdata(seg_wdata),
    .gate_we(gate_we), .gate_wdata(gate_wdata),
    .req_valid(req_valid), .req_sel(req_sel), .req_off(req_off),
    .lin_valid(lin_valid), .lin_addr(lin_addr), .lin_wrap(lin_wrap)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr_seg(input logic [1:0] sel, input logic [15:0] val);
    @(negedge clk);
    seg_we = 1'b1; seg_wsel = sel; seg_wdata = val;
    @(negedge clk);
    seg_we = 1'b0;
    model[sel] = val;
  endtask

  task automatic wr_gate(input logic val);
    @(negedge clk);
    gate_we = 1'b1; gate_wdata = val;
    @(negedge clk);
    gate_we = 1'b0;
    gate_m = val;
  endtask

  task automatic access(input string req, input logic [1:0] sel, input logic [15:0] off);
    int sum;
    logic [20:0] ea;
    @(negedge clk);
    req_valid = 1'b1; req_sel = sel; req_off = off;
    sum = int'(model[sel]) * 16 + int'(off);
    ea = gate_m ? 21'(sum) : 21'(sum % 1048576);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req, {31'b0, lin_valid}, 32'd1);
    chk(req, {11'b0, lin_addr}, {11'b0, ea});
    chk("R7", {31'b0, lin_wrap}, (sum >= 1048576) ? 32'd1 : 32'd0);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] sets [3][4];
    logic [20:0] held;
    sets[0] = '{16'h0000, 16'h1234, 16'hF000, 16'hFFFF};
    sets[1] = '{16'hFFF0, 16'h8000, 16'h0001, 16'hABCD};
    sets[2] = '{16'hF001, 16'h7FFF, 16'hFFFE, 16'h0FFF};
    rst_n = 1'b0; seg_we = 0; gate_we = 0; gate_wdata = 0; req_valid = 0;
    seg_wsel = 0; seg_wdata = 0; req_sel = 0; req_off = 0;
    for (int i = 0; i < 4; i++) model[i] = 16'h0;
    gate_m = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset outputs
    chk("R1", {31'b0, lin_valid}, 0);
    chk("R1", {11'b0, lin_addr}, 0);
    chk("R1", {31'b0, lin_wrap}, 0);
    rst_n = 1'b1;
    // R1 registers zero and gate masking: base 0 gives the offset only
    for (int s = 0; s < 4; s++) access("R1", 2'(s), 16'hFFFF);

    // R8 reset entry point
    wr_seg(2'd0, 16'hFFFF);
    access("R8", 2'd0, 16'h0000);
    // R6 masked fold-back
    access("R6", 2'd0, 16'h0010);
    // R5 open gate top address
    wr_gate(1'b1);
    access("R5", 2'd0, 16'hFFFF);
    chk("R5", {11'b0, lin_addr}, 32'h10FFEF);
    access("R5", 2'd0, 16'h0010);
    chk("R5", {11'b0, lin_addr}, 32'h100000);

    // R2 R3 R4 sweep of bases, selects, offsets and gate
    for (int g = 0; g < 2; g++) begin
      wr_gate(g[0]);
      for (int st = 0; st < 3; st++)
        for (int rot = 0; rot < 4; rot++) begin
          for (int r = 0; r < 4; r++) wr_seg(2'(r), sets[st][(r + rot) % 4]);
          for (int s = 0; s < 4; s++) begin
            for (int o = 0; o < 65536; o += 4093) access("R2", 2'(s), 16'(o));
            access("R3", 2'(s), 16'hFFFF);
          end
        end
    end

    // R4 a single write leaves the others alone
    wr_gate(1'b0);
    for (int r = 0; r < 4; r++) wr_seg(2'(r), 16'h1000 * 16'(r + 1));
    wr_seg(2'd2, 16'hBEEF);
    for (int s = 0; s < 4; s++) access("R4", 2'(s), 16'h0005);

    // R9 idle cycles hold the address and drop valid
    held = lin_addr;
    repeat (3) begin
      @(negedge clk);
      chk("R9", {31'b0, lin_valid}, 0);
      chk("R9", {11'b0, lin_addr}, {11'b0, held});
    end

    // R10 write and request in the same clock
    @(negedge clk);
    seg_we = 1'b1; seg_wsel = 2'd1; seg_wdata = 16'hFFFF;
    gate_we = 1'b1; gate_wdata = 1'b1;
    req_valid = 1'b1; req_sel = 2'd1; req_off = 16'hFFFF;
    @(negedge clk);
    seg_we = 0; gate_we = 0; req_valid = 0;
    chk("R10", {11'b0, lin_addr}, 32'h2000 * 16 + 32'hFFFF);
    model[1] = 16'hFFFF; gate_m = 1'b1;
    access("R10", 2'd1, 16'hFFFF);
    chk("R10", {11'b0, lin_addr}, 32'h10FFEF);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule